// File: doc/BRIEF.md
# Receive Flow Tag and Free-Queue Selector

This block sits in the receive path of one packet flow. When a packet starts, it builds the 32-bit tag word that goes into the outgoing packet descriptor, and it picks the free-descriptor queue that supplies the first buffer. The tag word has four bytes. Each byte has its own 3-bit selector. A selector can keep the byte already present in the descriptor, replace it with a configured constant, replace it with the flow number, or replace it with a byte of the tag that the back-end port reports.

The queue choice compares the reported packet size against up to three size thresholds. The thresholds must be enabled starting from the lowest. With k thresholds enabled, the block chooses among k+1 queues. A single 32-bit configuration word holds the four selectors and the threshold enable bits. The constants, thresholds and queue numbers come in as static inputs from the flow's other configuration registers. The configuration should only be rewritten while no channel is using the flow. If this rule is broken, a packet that starts in the same cycle as a write still sees the old word.

Size-based selection can be left out through a parameter. In that case the enable bits read as zero, cannot be written, and every packet takes queue 0.

Top module: `rx_flow_tag_qsel`

## Requirements
- R1: A `sop` pulse sampled at a clock edge makes `out_valid` high for exactly the next cycle. `out_tag`, `out_qidx` and `out_qnum` are registered at that same edge. `out_valid` is low in every cycle that does not follow a `sop`.
- R2: Source tag bytes. The selector in config bits 30:28 controls `out_tag[31:24]`, and the selector in bits 26:24 controls `out_tag[23:16]`. The codes are: 0 keeps the matching byte of `desc_tag_in`, 1 takes the matching byte of `tag_const`, 2 takes `flow_id`, and 4 takes the matching byte of `be_src_tag` (bits 15:8 for the high byte, bits 7:0 for the low byte).
- R3: Destination tag bytes. The selector in config bits 22:20 controls `out_tag[15:8]`, and the selector in bits 18:16 controls `out_tag[7:0]`. The codes are: 0 keeps the byte, 1 takes the matching byte of `tag_const`, 2 takes `flow_id`, 4 takes `be_dst_tag[7:0]`, and 5 takes `be_dst_tag[15:8]`.
- R4: Reserved selector codes keep the byte of `desc_tag_in` unchanged. These are 3, 5, 6 and 7 for the source selectors, and 3, 6 and 7 for the destination selectors.
- R5: With k thresholds enabled (enable value 1, 3 or 7 in config bits 2:0; threshold i is `thr_flat[i*SIZE_W +: SIZE_W]`), `out_qidx` is the lowest i below k for which `pkt_size` is less than or equal to threshold i. If the size is above every enabled threshold, `out_qidx` is k. `out_qnum` is `fdq_flat[out_qidx*QNUM_W +: QNUM_W]`.
- R6: With enable value 0, every packet takes queue index 0, whatever its size.
- R7: An illegal enable value (2, 4, 5 or 6) is stored as written. It acts only through its contiguous run of set bits starting at bit 0: 2 and 4 act as 0, 5 acts as 1, and 6 acts as 0. Writing such a value sets `cfg_err`, which stays high until reset.
- R8: A write stores `cfg_wdata` with every bit outside 30:28, 26:24, 22:20, 18:16 and 2:0 forced to zero. `cfg_rdata` returns the stored word in the cycle after the write. After reset the stored word is 0.
- R9: With `SIZE_SEL_EN` = 0, config bits 2:0 always read 0, `cfg_err` stays low, and every packet takes queue index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Stored configuration word |
| cfg_err | output | 1 | Sticky flag: an illegal threshold enable was written |
| tag_const | input | 32 | Constant bytes, aligned with the tag word |
| thr_flat | input | 3*SIZE_W | Size thresholds 0..2 |
| fdq_flat | input | 4*QNUM_W | Free queue numbers 0..3 |
| sop | input | 1 | Start-of-packet strobe |
| pkt_size | input | SIZE_W | Reported packet size |
| flow_id | input | 8 | Flow number |
| be_src_tag | input | 16 | Back-end source tag |
| be_dst_tag | input | 16 | Back-end destination tag |
| desc_tag_in | input | 32 | Tag word already present in the descriptor |
| out_valid | output | 1 | Result strobe |
| out_tag | output | 32 | Final tag word |
| out_qidx | output | 2 | Chosen free queue index |
| out_qnum | output | QNUM_W | Chosen free queue number |

## Verification
The assertions check the following on every cycle:
- `out_valid` follows `sop` by exactly one cycle.
- A readback after a write returns the masked word.
- `cfg_err` never falls once set.
- The queue index never exceeds the number of thresholds in force.
- Bytes under a keep code or a reserved code pass `desc_tag_in` through.

The bench scenarios cover what the assertions cannot:
- Every selector code is exercised against all four data sources.
- Packet sizes are placed exactly at, and one above, each threshold.
- Each illegal enable value is written, and its reduced prefix is observed in the queue choice.
- A build without size selection is run in parallel with the full build.

// File: rtl/rx_flow_tag_qsel.sv
module rx_flow_tag_qsel #(
  parameter int SIZE_W      = 16,
  parameter int QNUM_W      = 12,
  parameter bit SIZE_SEL_EN = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  output logic                cfg_err,
  input  logic [31:0]         tag_const,
  input  logic [3*SIZE_W-1:0] thr_flat,
  input  logic [4*QNUM_W-1:0] fdq_flat,
  input  logic                sop,
  input  logic [SIZE_W-1:0]   pkt_size,
  input  logic [7:0]          flow_id,
  input  logic [15:0]         be_src_tag,
  input  logic [15:0]         be_dst_tag,
  input  logic [31:0]         desc_tag_in,
  output logic                out_valid,
  output logic [31:0]         out_tag,
  output logic [1:0]          out_qidx,
  output logic [QNUM_W-1:0]   out_qnum
);

  localparam logic [31:0] CFG_MASK = SIZE_SEL_EN ? 32'h7777_0007 : 32'h7777_0000;

  logic [31:0] cfg_q;
  logic [2:0]  en;
  logic [1:0]  nthr;
  logic [1:0]  idx;
  logic [31:0] tag_d;
  logic        wr_bad;

  assign cfg_rdata = cfg_q;
  assign en        = cfg_q[2:0];
  assign nthr      = !en[0] ? 2'd0 : !en[1] ? 2'd1 : !en[2] ? 2'd2 : 2'd3;
  assign wr_bad    = SIZE_SEL_EN &&
                     ((cfg_wdata[1] && !cfg_wdata[0]) ||
                      (cfg_wdata[2] && !(cfg_wdata[1] && cfg_wdata[0])));

  function automatic logic [7:0] pick(input logic [2:0] sel, input logic [7:0] keep,
                                      input logic [7:0] k, input logic [7:0] fid,
                                      input logic [7:0] a, input logic [7:0] b);
    case (sel)
      3'd1:    pick = k;
      3'd2:    pick = fid;
      3'd4:    pick = a;
      3'd5:    pick = b;
      default: pick = keep;
    endcase
  endfunction

  assign tag_d[31:24] = pick(cfg_q[30:28], desc_tag_in[31:24], tag_const[31:24], flow_id,
                             be_src_tag[15:8], desc_tag_in[31:24]);
  assign tag_d[23:16] = pick(cfg_q[26:24], desc_tag_in[23:16], tag_const[23:16], flow_id,
                             be_src_tag[7:0], desc_tag_in[23:16]);
  assign tag_d[15:8]  = pick(cfg_q[22:20], desc_tag_in[15:8], tag_const[15:8], flow_id,
                             be_dst_tag[7:0], be_dst_tag[15:8]);
  assign tag_d[7:0]   = pick(cfg_q[18:16], desc_tag_in[7:0], tag_const[7:0], flow_id,
                             be_dst_tag[7:0], be_dst_tag[15:8]);

  always_comb begin
    idx = nthr;
    for (int i = 2; i >= 0; i--)
      if (2'(i) < nthr && pkt_size <= thr_flat[i*SIZE_W +: SIZE_W]) idx = 2'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      cfg_err   <= 1'b0;
      out_valid <= 1'b0;
      out_tag   <= '0;
      out_qidx  <= '0;
      out_qnum  <= '0;
    end else begin
      out_valid <= sop;
      if (sop) begin
        out_tag  <= tag_d;
        out_qidx <= idx;
        out_qnum <= fdq_flat[idx*QNUM_W +: QNUM_W];
      end
      if (cfg_we) begin
        cfg_q <= cfg_wdata & CFG_MASK;
        if (wr_bad) cfg_err <= 1'b1;
      end
    end
  end

  a_r1_valid_after_sop: assert property (@(posedge clk) disable iff (!rst_n)
    sop |=> out_valid);
  a_r1_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !sop |=> !out_valid);
  a_r2_src_hi_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (sop && cfg_q[30:28] == 3'd0) |=> out_tag[31:24] == $past(desc_tag_in[31:24]));
  a_r4_dst_lo_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (sop && (cfg_q[18:16] == 3'd3 || cfg_q[18:16] >= 3'd6)) |=> out_tag[7:0] == $past(desc_tag_in[7:0]));
  a_r5_qidx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sop |=> out_qidx <= $past(nthr));
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
  a_r8_readback: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == ($past(cfg_wdata) & CFG_MASK));

  generate
    if (!SIZE_SEL_EN) begin : g_nosz
      a_r9_no_size_sel: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[2:0] == 3'd0 && !cfg_err && (out_valid -> out_qidx == 2'd0));
    end
  endgenerate

endmodule

// File: tb/test_rx_flow_tag_qsel.sv
`timescale 1ns/1ps
module test_rx_flow_tag_qsel;
  localparam int SW = 16, QW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic cfg_we = 1'b0, sop = 1'b0;
  logic [31:0] cfg_wdata = '0, tag_const = 32'hC3A5_5A3C, desc_tag_in = '0;
  logic [3*SW-1:0] thr_flat = {16'd1024, 16'd256, 16'd64};
  logic [4*QW-1:0] fdq_flat = {12'h404, 12'h303, 12'h202, 12'h101};
  logic [SW-1:0] pkt_size = '0;
  logic [7:0] flow_id = '0;
  logic [15:0] be_src_tag = '0, be_dst_tag = '0;
  logic [31:0] cfg_rdata, out_tag, n_rdata, n_tag;
  logic cfg_err, out_valid, n_err, n_valid;
  logic [1:0] out_qidx, n_qidx;
  logic [QW-1:0] out_qnum, n_qnum;

  rx_flow_tag_qsel #(.SIZE_W(SW), .QNUM_W(QW), .SIZE_SEL_EN(1'b1)) i_rx_flow_tag_qsel (
    .clk, .rst_n, .cfg_we, .cfg_wdata, .cfg_rdata, .cfg_err, .tag_const, .thr_flat,
    .fdq_flat, .sop, .pkt_size, .flow_id, .be_src_tag, .be_dst_tag, .desc_tag_in,
    .out_valid, .out_tag, .out_qidx, .out_qnum);

  rx_flow_tag_qsel #(.SIZE_W(SW), .QNUM_W(QW), .SIZE_SEL_EN(1'b0)) i_nosz (
    .clk, .rst_n, .cfg_we, .cfg_wdata, .cfg_rdata(n_rdata), .cfg_err(n_err), .tag_const,
    .thr_flat, .fdq_flat, .sop, .pkt_size, .flow_id, .be_src_tag, .be_dst_tag, .desc_tag_in,
    .out_valid(n_valid), .out_tag(n_tag), .out_qidx(n_qidx), .out_qnum(n_qnum));

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model
  logic [31:0] m_cfg = '0, e_tag = '0;
  logic m_err = 1'b0, e_valid = 1'b0, e_bad = 1'b0;
  int e_q = 0, e_n = 0;
  logic [2:0] e_sel [4];

  function automatic logic [7:0] ref_byte(input int sel, input bit dst, input logic [7:0] keep,
                                          input logic [7:0] k, input logic [15:0] be, input bit hi);
    if (sel == 1) return k;
    if (sel == 2) return flow_id;
    if (sel == 4) return (dst || !hi) ? be[7:0] : be[15:8];
    if (sel == 5 && dst) return be[15:8];
    return keep;
  endfunction

  function automatic bit is_rsv(input int sel, input bit dst);
    return sel == 3 || sel >= 6 || (sel == 5 && !dst);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = '0; m_err = 1'b0; e_valid = 1'b0;
    end else begin
      e_valid = sop;
      if (sop) begin
        int n;
        n = 0;
        for (int i = 0; i < 3; i++) if (m_cfg[i] && n == i) n++;
        e_n = n;
        e_q = n;
        for (int i = n - 1; i >= 0; i--) if (pkt_size <= thr_flat[i*SW +: SW]) e_q = i;
        e_bad = (m_cfg[2:0] != 0 && m_cfg[2:0] != 1 && m_cfg[2:0] != 3 && m_cfg[2:0] != 7);
        e_sel[3] = m_cfg[30:28]; e_sel[2] = m_cfg[26:24];
        e_sel[1] = m_cfg[22:20]; e_sel[0] = m_cfg[18:16];
        e_tag[31:24] = ref_byte(m_cfg[30:28], 0, desc_tag_in[31:24], tag_const[31:24], be_src_tag, 1);
        e_tag[23:16] = ref_byte(m_cfg[26:24], 0, desc_tag_in[23:16], tag_const[23:16], be_src_tag, 0);
        e_tag[15:8]  = ref_byte(m_cfg[22:20], 1, desc_tag_in[15:8], tag_const[15:8], be_dst_tag, 1);
        e_tag[7:0]   = ref_byte(m_cfg[18:16], 1, desc_tag_in[7:0], tag_const[7:0], be_dst_tag, 0);
      end
      if (cfg_we) begin
        m_cfg = {1'b0, cfg_wdata[30:28], 1'b0, cfg_wdata[26:24], 1'b0, cfg_wdata[22:20],
                 1'b0, cfg_wdata[18:16], 13'd0, cfg_wdata[2:0]};
        if (!(cfg_wdata[2:0] inside {3'd0, 3'd1, 3'd3, 3'd7})) m_err = 1'b1;
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk("R1 valid", {31'd0, out_valid}, {31'd0, e_valid});
    chk("R8 readback", cfg_rdata, m_cfg);
    chk("R7 sticky err", {31'd0, cfg_err}, {31'd0, m_err});
    chk("R9 nosz readback", n_rdata, {m_cfg[31:3], 3'd0});
    chk("R9 nosz err", {31'd0, n_err}, 32'd0);
    if (e_valid) begin
      for (int b = 0; b < 4; b++)
        chk(is_rsv(e_sel[b], b < 2) ? "R4 reserved byte" : (b < 2 ? "R3 dst byte" : "R2 src byte"),
            {24'd0, out_tag[b*8 +: 8]}, {24'd0, e_tag[b*8 +: 8]});
      chk(e_bad ? "R7 illegal enable qidx" : (e_n == 0 ? "R6 no threshold qidx" : "R5 qidx"),
          {30'd0, out_qidx}, 32'(e_q));
      chk("R5 qnum", {20'd0, out_qnum}, {20'd0, fdq_flat[e_q*QW +: QW]});
      chk("R9 nosz qidx", {30'd0, n_qidx}, 32'd0);
      chk("R9 nosz qnum", {20'd0, n_qnum}, {20'd0, fdq_flat[QW-1:0]});
      chk("R9 nosz tag", n_tag, e_tag);
    end
  end

  task automatic wr(input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic pkt(input int size, input bit hold = 0);
    @(negedge clk);
    sop = 1'b1; pkt_size = SW'(size); flow_id = 8'($urandom);
    be_src_tag = 16'($urandom); be_dst_tag = 16'($urandom); desc_tag_in = $urandom;
    if (!hold) begin @(negedge clk); sop = 1'b0; end
  endtask

  function automatic logic [31:0] mk(input int sh, input int sl, input int dh, input int dl, input int en);
    return {1'b0, 3'(sh), 1'b0, 3'(sl), 1'b0, 3'(dh), 1'b0, 3'(dl), 13'd0, 3'(en)};
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1; checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {31'd0, out_valid}, 32'd0);
    chk("R8 reset cfg", cfg_rdata, 32'd0);
    chk("R7 reset err", {31'd0, cfg_err}, 32'd0);
    rst_n = 1'b1;
    wr(32'hFFFF_FFFF);
    wr(mk(1, 2, 4, 5, 7));
    foreach (thr_flat[i]) ;
    pkt(10); pkt(64); pkt(65); pkt(256); pkt(257); pkt(1024); pkt(1025); pkt(0);
    wr(mk(4, 4, 2, 1, 1)); pkt(64); pkt(65);
    wr(mk(0, 1, 0, 4, 3)); pkt(300); pkt(100); pkt(256); pkt(257);
    wr(mk(3, 5, 3, 6, 0)); pkt(5000); pkt(0);
    wr(mk(6, 7, 7, 3, 0)); pkt(1);
    wr(mk(0, 0, 5, 5, 2)); pkt(10); pkt(5000);
    wr(mk(1, 1, 1, 1, 4)); pkt(10);
    wr(mk(2, 2, 2, 2, 5)); pkt(10); pkt(65);
    wr(mk(0, 0, 0, 0, 6)); pkt(10);
    for (int n = 0; n < 600; n++) begin
      if ($urandom_range(0, 9) == 0) wr($urandom);
      pkt($urandom_range(0, 1100), $urandom_range(0, 1) == 1);
      if ($urandom_range(0, 3) == 0) begin @(negedge clk); sop = 1'b0; end
    end
    @(negedge clk); sop = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule